// File: doc/BRIEF.md
# True dual-port synchronous RAM

This block is a memory with two ports, A and B, that share one storage array and nothing else. Each port has its own clock, synchronous reset, enable, write strobe, address, input data bus and output data bus. On any cycle, each port can read or write, and both ports can write at the same time. Every access takes effect on a rising edge of that port's clock. Read data appears on the port's registered output after the edge. It is never a combinational function of the address.

Each port has an elaboration-time write mode. The mode sets what that port's output shows after it writes:
- the word just written,
- the word the location held before the write, or
- the output's previous value, unchanged.

The input and output data buses are separate. The outputs are always driven and have no high-impedance state. A typical use is a clock-crossing buffer, with one port dedicated to writes and the other to reads. Other uses are a shared table accessed from two sides, or a scratch store that both ports update.

Top module: `tdp_ram`

## Requirements
- R1: A word written through either port can be read back through the other port, because both ports address the same locations.
- R2: When a port has enable 1 and write strobe 0, its output shows, one rising edge later, the word held at the address sampled on that edge.
- R3: During a read (enable 1, write strobe 0), the port's input data bus has no effect on the output or on the stored contents.
- R4: A port in write-first mode (mode code 0) shows, after a write edge, the word written on that edge.
- R5: A port in read-first mode (mode code 1) shows, after a write edge, the word the addressed location held just before that edge.
- R6: A port in no-change mode (mode code 2) keeps its output unchanged across a write edge.
- R7: While a port's enable is 0, that port neither reads nor writes, whatever its write strobe is, and its output holds its previous value.
- R8: Both ports may write in the same cycle, and writes to different addresses are both stored.
- R9: If both ports write the same address on the same edge of a shared clock, the location keeps port A's word.
- R10: A port's reset, sampled high on its clock edge, sets that port's output to zero. It leaves the other port and the stored contents untouched, and a write presented during reset is still stored.
- R11: When one port writes a location and the other port reads it on the same edge of a shared clock, the reader sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset of the output, active high |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write strobe, used only with en_a |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A registered output data |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset of the output, active high |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write strobe, used only with en_b |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B registered output data |

## Verification
A corrupt word in either storage bank cannot stay hidden. Because a word is rebuilt by combining the two banks, the next read of that address through either port shows the corruption one edge later. A fault in the collision handling shows up the same way on the first read-back after a same-address double write. A wrong output-register update shows directly on the port output at the edge that caused it. Such faults include the wrong write mode, an idle port that still reloads, or a reset that spills into the other port. The bench compares all four outputs of two instances, which together cover every write mode, after every edge.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    // Output behaviour of a port on a write edge
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

endpackage

// File: rtl/tdp_bank.sv
// One storage bank: a single write port on its own clock and
// asynchronous read taps at every port address.
module tdp_bank #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned ADDR_W = $clog2(DEPTH),
    parameter int unsigned NRD    = 2
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NRD-1:0][ADDR_W-1:0]   raddr,
    output logic [NRD-1:0][DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_tap
        assign rdata[r] = mem_q[raddr[r]];
    end

endmodule

// File: rtl/tdp_port.sv
// Output register of one port, with the write-mode selection.
module tdp_port
    import tdp_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter wmode_e      MODE   = WM_WRITE_FIRST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              we,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] dout
);

    typedef struct packed {
        logic [DATA_W-1:0] dout;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.dout = '0;
        end else if (en) begin
            if (!we) begin
                st_d.dout = stored;
            end else begin
                case (MODE)
                    WM_WRITE_FIRST: st_d.dout = din;
                    WM_READ_FIRST:  st_d.dout = stored;
                    default:        st_d.dout = st_q.dout;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.dout;

endmodule

// File: rtl/tdp_ram.sv
// True dual-port RAM. Each port owns one bank. A stored word is the XOR of
// both banks at that address, so each bank has exactly one writer.
module tdp_ram
    import tdp_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned ADDR_W = $clog2(DEPTH),
    parameter wmode_e      MODE_A = WM_WRITE_FIRST,
    parameter wmode_e      MODE_B = WM_NO_CHANGE
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              en_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] din_a,
    output logic [DATA_W-1:0] dout_a,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              en_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] dout_b
);

    localparam int unsigned NP = 2;

    logic [NP-1:0]                      clk_v, rst_v, en_v, we_v, wr_v;
    logic [NP-1:0][ADDR_W-1:0]          addr_v;
    logic [NP-1:0][DATA_W-1:0]          din_v, dout_v;
    logic [NP-1:0][NP-1:0][DATA_W-1:0]  word_v;   // [bank][port address]
    logic                               b_yield;

    assign clk_v  = {clk_b,  clk_a};
    assign rst_v  = {rst_b,  rst_a};
    assign en_v   = {en_b,   en_a};
    assign we_v   = {we_b,   we_a};
    assign addr_v = {addr_b, addr_a};
    assign din_v  = {din_b,  din_a};

    // Same-address double write: port B drops its write so port A's word stays
    assign b_yield = en_a & we_a & en_b & we_b & (addr_a == addr_b);
    assign wr_v[0] = en_a & we_a;
    assign wr_v[1] = en_b & we_b & ~b_yield;

    for (genvar p = 0; p < NP; p++) begin : g_port
        localparam wmode_e PMODE = (p == 0) ? MODE_A : MODE_B;

        tdp_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH),
            .ADDR_W (ADDR_W),
            .NRD    (NP)
        ) u_bank (
            .clk   (clk_v[p]),
            .we    (wr_v[p]),
            .waddr (addr_v[p]),
            .wdata (din_v[p] ^ word_v[NP-1-p][p]),
            .raddr (addr_v),
            .rdata (word_v[p])
        );

        tdp_port #(
            .DATA_W (DATA_W),
            .MODE   (PMODE)
        ) u_port (
            .clk    (clk_v[p]),
            .rst    (rst_v[p]),
            .en     (en_v[p]),
            .we     (we_v[p]),
            .din    (din_v[p]),
            .stored (word_v[0][p] ^ word_v[1][p]),
            .dout   (dout_v[p])
        );
    end

    assign dout_a = dout_v[0];
    assign dout_b = dout_v[1];

endmodule

// File: rtl/tdp_ram_chk.sv
module tdp_ram_chk
    import tdp_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter wmode_e      MODE_A = WM_WRITE_FIRST,
    parameter wmode_e      MODE_B = WM_NO_CHANGE
) (
    input logic              clk_a,
    input logic              rst_a,
    input logic              en_a,
    input logic              we_a,
    input logic [DATA_W-1:0] din_a,
    input logic [DATA_W-1:0] dout_a,
    input logic              clk_b,
    input logic              rst_b,
    input logic              en_b,
    input logic              we_b,
    input logic [DATA_W-1:0] din_b,
    input logic [DATA_W-1:0] dout_b
);

    AST_A_IDLE_HOLD: assert property (@(posedge clk_a) disable iff (rst_a)
        !en_a |=> $stable(dout_a)); // R7

    AST_B_IDLE_HOLD: assert property (@(posedge clk_b) disable iff (rst_b)
        !en_b |=> $stable(dout_b)); // R7

    if (MODE_A == WM_WRITE_FIRST) begin : g_a_wf
        AST_A_WRITE_FIRST: assert property (@(posedge clk_a) disable iff (rst_a)
            (en_a && we_a) |=> (dout_a == $past(din_a))); // R4
    end else if (MODE_A == WM_NO_CHANGE) begin : g_a_nc
        AST_A_NO_CHANGE: assert property (@(posedge clk_a) disable iff (rst_a)
            (en_a && we_a) |=> $stable(dout_a)); // R6
    end

    if (MODE_B == WM_WRITE_FIRST) begin : g_b_wf
        AST_B_WRITE_FIRST: assert property (@(posedge clk_b) disable iff (rst_b)
            (en_b && we_b) |=> (dout_b == $past(din_b))); // R4
    end else if (MODE_B == WM_NO_CHANGE) begin : g_b_nc
        AST_B_NO_CHANGE: assert property (@(posedge clk_b) disable iff (rst_b)
            (en_b && we_b) |=> $stable(dout_b)); // R6
    end

endmodule

bind tdp_ram tdp_ram_chk #(
    .DATA_W (DATA_W),
    .MODE_A (MODE_A),
    .MODE_B (MODE_B)
) u_chk (
    .clk_a  (clk_a),
    .rst_a  (rst_a),
    .en_a   (en_a),
    .we_a   (we_a),
    .din_a  (din_a),
    .dout_a (dout_a),
    .clk_b  (clk_b),
    .rst_b  (rst_b),
    .en_b   (en_b),
    .we_b   (we_b),
    .din_b  (din_b),
    .dout_b (dout_b)
);

// File: tb/tdp_ram_bench.sv
module tdp_ram_bench;
    import tdp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW  = 16;
    localparam int DEP = 16;
    localparam int AW  = 4;

    logic          clk = 1'b0;
    logic          rst_a, rst_b, en_a, en_b, we_a, we_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [DW-1:0] din_a, din_b;
    logic [DW-1:0] d1a, d1b, d2a, d2b;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Instance 1: A write-first, B read-first
    tdp_ram #(.DATA_W(DW), .DEPTH(DEP), .ADDR_W(AW),
              .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST)) u_tdp_ram (
        .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dout_a(d1a),
        .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .dout_b(d1b));

    // Instance 2: A no-change, B write-first
    tdp_ram #(.DATA_W(DW), .DEPTH(DEP), .ADDR_W(AW),
              .MODE_A(WM_NO_CHANGE), .MODE_B(WM_WRITE_FIRST)) u_tdp_ram_alt (
        .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dout_a(d2a),
        .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .dout_b(d2b));

    // Model state; outputs in order: inst1 A, inst1 B, inst2 A, inst2 B
    logic [DW-1:0] mem_m [DEP];
    logic [DW-1:0] exp_v [4];
    string         tag_v [4];
    localparam int MODE_OF [4] = '{0, 1, 2, 0};

    function automatic logic [DW-1:0] nxt(int mode, logic rst, logic en, logic we,
                                          logic [DW-1:0] din, logic [DW-1:0] old,
                                          logic [DW-1:0] cur);
        if (rst) return '0;
        if (!en) return cur;
        if (!we) return old;
        case (mode)
            0:       return din;
            1:       return old;
            default: return cur;
        endcase
    endfunction

    function automatic string tag_of(int mode, logic rst, logic en, logic we);
        if (rst) return "R10";
        if (!en) return "R7";
        if (!we) return "R2";
        case (mode)
            0:       return "R4";
            1:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic drive(logic ra, logic rb, logic ea, logic wa, int aa, logic [DW-1:0] da,
                         logic eb, logic wb, int ab, logic [DW-1:0] db);
        rst_a = ra; rst_b = rb;
        en_a = ea; we_a = wa; addr_a = AW'(aa); din_a = da;
        en_b = eb; we_b = wb; addr_b = AW'(ab); din_b = db;
    endtask

    // Inputs already applied at a falling edge; predict, run one edge, compare
    task automatic step(string ctx);
        logic [DW-1:0] old_a, old_b, act;
        old_a = mem_m[addr_a];
        old_b = mem_m[addr_b];
        for (int i = 0; i < 4; i++) begin
            if (i % 2 == 0) begin
                exp_v[i] = nxt(MODE_OF[i], rst_a, en_a, we_a, din_a, old_a, exp_v[i]);
                tag_v[i] = tag_of(MODE_OF[i], rst_a, en_a, we_a);
            end else begin
                exp_v[i] = nxt(MODE_OF[i], rst_b, en_b, we_b, din_b, old_b, exp_v[i]);
                tag_v[i] = tag_of(MODE_OF[i], rst_b, en_b, we_b);
            end
            if (ctx != "") tag_v[i] = ctx;
        end
        // B first, then A, so port A wins a same-address collision
        if (en_b && we_b) mem_m[addr_b] = din_b;
        if (en_a && we_a) mem_m[addr_a] = din_a;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            case (i)
                0:       act = d1a;
                1:       act = d1b;
                2:       act = d2a;
                default: act = d2b;
            endcase
            checks++;
            if (act !== exp_v[i]) begin
                errors++;
                $display("FAIL %s output %0d: actual %h expected %h", tag_v[i], i, act, exp_v[i]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) exp_v[i] = '0;
        for (int i = 0; i < DEP; i++) mem_m[i] = 'x;
        drive(1, 1, 0, 0, 0, '0, 0, 0, 0, '0);
        @(negedge clk);
        step("R10");
        step("R10");

        // Fill every word through port A
        for (int i = 0; i < DEP; i++) begin
            drive(0, 0, 1, 1, i, DW'($urandom()), 0, 0, 0, '0);
            step("");
        end

        // R1: cross-port visibility in both directions
        drive(0, 0, 0, 0, 0, '0, 1, 0, 3, '0);          step("R1");
        drive(0, 0, 0, 0, 0, '0, 1, 1, 9, 16'hC0DE);    step("R1");
        drive(0, 0, 1, 0, 9, '0, 0, 0, 0, '0);          step("R1");

        // R3: input data ignored on reads
        drive(0, 0, 1, 0, 4, 16'hFFFF, 1, 0, 4, 16'h1234); step("R3");
        drive(0, 0, 1, 0, 4, 16'h0000, 1, 0, 4, 16'h0000); step("R3");

        // R7: write strobe with enable low has no effect
        drive(0, 0, 0, 1, 5, 16'hAAAA, 0, 1, 6, 16'h5555); step("R7");
        drive(0, 0, 1, 0, 5, '0, 1, 0, 6, '0);             step("R7");

        // R8: simultaneous writes to different addresses
        drive(0, 0, 1, 1, 1, 16'h1111, 1, 1, 2, 16'h2222); step("R8");
        drive(0, 0, 1, 0, 2, '0, 1, 0, 1, '0);             step("R8");

        // R9: same-address collision, port A wins
        drive(0, 0, 1, 1, 10, 16'hA5A5, 1, 1, 10, 16'h5A5A); step("R9");
        drive(0, 0, 1, 0, 10, '0, 1, 0, 10, '0);             step("R9");

        // R11: write on A, read on B, same edge
        drive(0, 0, 1, 1, 7, 16'h7777, 1, 0, 7, '0); step("R11");
        drive(0, 0, 0, 0, 0, '0, 1, 0, 7, '0);       step("R11");

        // R10: reset of A only; write still stored, B unaffected
        drive(1, 0, 1, 1, 8, 16'h8888, 1, 0, 8, '0); step("R10");
        drive(0, 0, 1, 0, 8, '0, 1, 0, 8, '0);       step("R10");

        // Constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            drive(($urandom() % 64) == 0, ($urandom() % 64) == 0,
                  ($urandom() % 4) != 0, ($urandom() % 2) == 1,
                  int'($urandom() % DEP), DW'($urandom()),
                  ($urandom() % 4) != 0, ($urandom() % 2) == 1,
                  int'($urandom() % DEP), DW'($urandom()));
            step("");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule